// File: doc/BRIEF.md
# Multi-Cycle Fetch-Decode-Execute Core

This block is a small processor core with four 8-bit general registers and no branch support. It runs one instruction at a time through a fixed loop of phases. Fetch takes two cycles: the first presents the program counter to a synchronous instruction memory, and the second captures the returned 16-bit word into the instruction register. Decode takes one cycle and advances the program counter by two bytes to the next sequential instruction. Execute takes one cycle, or two for a load. Arithmetic results go straight into the register file. Loads and stores use a separate byte-wide data port that has one cycle of read latency.

Each instruction is 16 bits. Bits 15:14 hold the opcode: 00 add, 01 subtract, 10 load, 11 store. For add and subtract, bits 13:12 select the first source register, bits 11:10 the second source and bits 9:8 the destination. For load and store, bits 9:8 select the register and bits 7:0 hold the absolute data byte address. Register codes 0 to 3 select A to D. Debug outputs show the program counter, the instruction register and all four registers, so an integrator or a bench can follow the program.

Top module: `fetch_exec_core`

## Requirements
- R1: While reset is high, the program counter equals the RESET_PC parameter, and the instruction register and all four registers read zero.
- R2: After reset the phases repeat in this order: fetch-address, fetch-capture, decode, execute. A load adds one load-wait phase after execute.
- R3: instrAddr always equals the program counter. The instruction register loads instrRdata only at the end of fetch-capture and holds its value at all other times.
- R4: The program counter rises by exactly 2 at the end of the decode phase and does not change in any other cycle.
- R5: Add writes (src1 + src2) mod 256 to the destination, and subtract writes (src1 - src2) mod 256. The write happens at the end of execute, and the fields are taken from bits 13:12, 11:10 and 9:8.
- R6: A load asserts dataRe with dataAddr equal to bits 7:0 during execute. The selected register takes dataRdata at the end of the following load-wait cycle.
- R7: A store asserts dataWe for exactly one cycle, during execute, with dataAddr equal to bits 7:0 and dataWdata equal to the register selected by bits 9:8.
- R8: A register changes only when an arithmetic or load instruction writes it. dataWe stays low outside the execute cycle of a store.
- R9: With RESET_PC = 500, the program load 12 to A, load 13 to B, add A and B to C, store C to 14 leaves the program counter at 508 after the fourth execute. Location 14 then holds the 8-bit sum of locations 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrAddr | output | PC_W | Byte address of the instruction being fetched |
| instrRdata | input | 16 | Instruction word, valid one cycle after the address |
| dataAddr | output | 8 | Data byte address |
| dataRe | output | 1 | Data read strobe (load execute) |
| dataWe | output | 1 | Data write strobe (store execute) |
| dataWdata | output | DATA_W | Data byte to write |
| dataRdata | input | DATA_W | Data byte read, valid one cycle after dataRe |
| dbgPc | output | PC_W | Program counter |
| dbgIr | output | 16 | Instruction register |
| dbgRegs | output | 4*DATA_W | Registers A (low byte) to D (high byte) |

## Verification
The assertions check the phase sequence on every cycle. They also check that the program counter moves only by +2 after decode, that the instruction register and the registers hold when no write strobe was issued, and that a store strobe lasts a single cycle. Only the bench scenarios can show that the values are correct: the modulo-256 sums and differences, the byte a load returns, the byte a store leaves in memory, and the final program counter and memory contents of the sample program. For these the bench runs a behavioural model alongside the core.

// File: rtl/fec_pkg.sv
package fec_pkg;

  localparam int INSTR_W = 16;
  localparam int REG_SEL_W = 2;
  localparam int NUM_REGS = 1 << REG_SEL_W;
  localparam int DADDR_W = 8;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOAD  = 2'b10,
    OP_STORE = 2'b11
  } opcode_t;

  typedef enum logic [2:0] {
    PH_FETCH_ADDR,
    PH_FETCH_CAPT,
    PH_DECODE,
    PH_EXEC,
    PH_LOAD_WAIT
  } phase_t;

  typedef struct packed {
    logic irLoad;
    logic pcInc;
    logic aluWr;
    logic loadWr;
    logic memRd;
    logic memWr;
  } strobe_t;

endpackage

// File: rtl/fec_alu.sv
module fec_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              subtract,
  output logic [DATA_W-1:0] result
);
  // Results wrap modulo 2**DATA_W; no flags are kept.
  always_comb begin
    if (subtract) result = opA - opB;
    else          result = opA + opB;
  end
endmodule

// File: rtl/fec_ctrl.sv
module fec_ctrl
  import fec_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_t opcode,
  output strobe_t strb
);
  phase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH_ADDR;
    else     phase <= phaseNext;
  end

  always_comb begin
    unique case (phase)
      PH_FETCH_ADDR: phaseNext = PH_FETCH_CAPT;
      PH_FETCH_CAPT: phaseNext = PH_DECODE;
      PH_DECODE:     phaseNext = PH_EXEC;
      PH_EXEC:       phaseNext = (opcode == OP_LOAD) ? PH_LOAD_WAIT : PH_FETCH_ADDR;
      PH_LOAD_WAIT:  phaseNext = PH_FETCH_ADDR;
      default:       phaseNext = PH_FETCH_ADDR;
    endcase
  end

  always_comb begin
    strb        = '0;
    strb.irLoad = (phase == PH_FETCH_CAPT);
    strb.pcInc  = (phase == PH_DECODE);
    strb.aluWr  = (phase == PH_EXEC) && (opcode == OP_ADD || opcode == OP_SUB);
    strb.memRd  = (phase == PH_EXEC) && (opcode == OP_LOAD);
    strb.memWr  = (phase == PH_EXEC) && (opcode == OP_STORE);
    strb.loadWr = (phase == PH_LOAD_WAIT);
  end

  // R2: phase order
  a_r2_addr_to_capt: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH_ADDR |=> phase == PH_FETCH_CAPT);
  a_r2_capt_to_decode: assert property (@(posedge clk) disable iff (rst)
    phase == PH_FETCH_CAPT |=> phase == PH_DECODE);
  a_r2_decode_to_exec: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DECODE |=> phase == PH_EXEC);
  // R6: a load always gets its wait cycle
  a_r6_load_wait: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && opcode == OP_LOAD) |=> phase == PH_LOAD_WAIT);
  a_r2_wait_to_fetch: assert property (@(posedge clk) disable iff (rst)
    phase == PH_LOAD_WAIT |=> phase == PH_FETCH_ADDR);
endmodule

// File: rtl/fec_dpath.sv
module fec_dpath
  import fec_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strb,
  output opcode_t                    opcode,
  output logic [PC_W-1:0]            instrAddr,
  input  logic [INSTR_W-1:0]         instrRdata,
  output logic [DADDR_W-1:0]         dataAddr,
  output logic                       dataRe,
  output logic                       dataWe,
  output logic [DATA_W-1:0]          dataWdata,
  input  logic [DATA_W-1:0]          dataRdata,
  output logic [PC_W-1:0]            pcOut,
  output logic [INSTR_W-1:0]         irOut,
  output logic [NUM_REGS*DATA_W-1:0] regsFlat
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_W / 8);

  logic [PC_W-1:0]      pc;
  logic [INSTR_W-1:0]   ir;
  logic [DATA_W-1:0]    regFile [NUM_REGS];
  logic [REG_SEL_W-1:0] selSrc1, selSrc2, selDst;
  logic [DATA_W-1:0]    aluY;

  assign opcode  = opcode_t'(ir[15:14]);
  assign selSrc1 = ir[13:12];
  assign selSrc2 = ir[11:10];
  assign selDst  = ir[9:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
      ir <= '0;
    end else begin
      if (strb.irLoad) ir <= instrRdata;
      if (strb.pcInc)  pc <= pc + PC_STEP;
    end
  end

  fec_alu #(.DATA_W(DATA_W)) u_alu (
    .opA      (regFile[selSrc1]),
    .opB      (regFile[selSrc2]),
    .subtract (ir[14]),
    .result   (aluY)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (strb.aluWr) begin
      regFile[selDst] <= aluY;
    end else if (strb.loadWr) begin
      regFile[selDst] <= dataRdata;
    end
  end

  assign instrAddr = pc;
  assign dataAddr  = ir[DADDR_W-1:0];
  assign dataRe    = strb.memRd;
  assign dataWe    = strb.memWr;
  assign dataWdata = regFile[selDst];
  assign pcOut     = pc;
  assign irOut     = ir;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regsFlat[g*DATA_W +: DATA_W] = regFile[g];
  end

  // R4: the program counter steps by two after decode and holds otherwise
  a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
    $past(strb.pcInc) |-> pc == $past(pc) + PC_STEP);
  a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.pcInc) |-> $stable(pc));
  // R3: the instruction register holds outside fetch-capture
  a_r3_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.irLoad) |-> $stable(ir));
  // R8: registers hold when no write strobe was issued
  a_r8_regs_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.aluWr || strb.loadWr) |-> $stable(regsFlat));
  // R7: a store strobe lasts a single cycle
  a_r7_store_single: assert property (@(posedge clk) disable iff (rst)
    dataWe |=> !dataWe);
endmodule

// File: rtl/fetch_exec_core.sv
module fetch_exec_core #(
  parameter int unsigned PC_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   instrAddr,
  input  logic [15:0]       instrRdata,
  output logic [7:0]        dataAddr,
  output logic              dataRe,
  output logic              dataWe,
  output logic [DATA_W-1:0] dataWdata,
  input  logic [DATA_W-1:0] dataRdata,
  output logic [PC_W-1:0]   dbgPc,
  output logic [15:0]       dbgIr,
  output logic [4*DATA_W-1:0] dbgRegs
);
  import fec_pkg::*;

  strobe_t strb;
  opcode_t opcode;

  fec_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .strb   (strb)
  );

  fec_dpath #(
    .PC_W     (PC_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .opcode     (opcode),
    .instrAddr  (instrAddr),
    .instrRdata (instrRdata),
    .dataAddr   (dataAddr),
    .dataRe     (dataRe),
    .dataWe     (dataWe),
    .dataWdata  (dataWdata),
    .dataRdata  (dataRdata),
    .pcOut      (dbgPc),
    .irOut      (dbgIr),
    .regsFlat   (dbgRegs)
  );
endmodule

// File: tb/fetch_exec_core_tb.sv
module fetch_exec_core_tb;
  localparam int PC_W = 16;
  localparam int START = 500;

  logic clk = 0;
  logic rst = 1;
  logic [PC_W-1:0] instrAddr;
  logic [15:0] instrRdata;
  logic [7:0] dataAddr;
  logic dataRe, dataWe;
  logic [7:0] dataWdata, dataRdata;
  logic [PC_W-1:0] dbgPc;
  logic [15:0] dbgIr;
  logic [31:0] dbgRegs;

  always #5 clk = ~clk;

  fetch_exec_core #(.PC_W(PC_W), .DATA_W(8), .RESET_PC(16'(START))) u_dut (
    .clk(clk), .rst(rst), .instrAddr(instrAddr), .instrRdata(instrRdata),
    .dataAddr(dataAddr), .dataRe(dataRe), .dataWe(dataWe), .dataWdata(dataWdata),
    .dataRdata(dataRdata), .dbgPc(dbgPc), .dbgIr(dbgIr), .dbgRegs(dbgRegs)
  );

  // Memories seen by the core
  logic [15:0] imem [0:511];
  logic [7:0]  dmem [0:255];
  always @(posedge clk) begin
    instrRdata <= imem[instrAddr[9:1]];
    dataRdata  <= dmem[dataAddr];
    if (dataWe) dmem[dataAddr] <= dataWdata;
  end

  // Behavioural reference model
  int          mPhase;
  int          mPc;
  logic [15:0] mIr;
  logic [7:0]  mRegs [0:3];
  logic [7:0]  mMem [0:255];
  int          mRetired;

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mPc = START; mIr = 0; mRetired = 0;
      for (int i = 0; i < 4; i++) mRegs[i] = 0;
    end else begin
      case (mPhase)
        0: mPhase = 1;
        1: begin mIr = imem[(mPc % 1024) / 2]; mPhase = 2; end
        2: begin mPc = mPc + 2; mPhase = 3; end
        3: begin
          case (mIr[15:14])
            2'b00: begin mRegs[mIr[9:8]] = 8'(int'(mRegs[mIr[13:12]]) + int'(mRegs[mIr[11:10]])); mPhase = 0; mRetired++; end
            2'b01: begin mRegs[mIr[9:8]] = 8'(int'(mRegs[mIr[13:12]]) - int'(mRegs[mIr[11:10]])); mPhase = 0; mRetired++; end
            2'b10: mPhase = 4;
            default: begin mMem[mIr[7:0]] = mRegs[mIr[9:8]]; mPhase = 0; mRetired++; end
          endcase
        end
        default: begin mRegs[mIr[9:8]] = mMem[mIr[7:0]]; mPhase = 0; mRetired++; end
      endcase
    end
  end

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

  initial begin
    int lastRetired;
    for (int i = 0; i < 512; i++) imem[i] = 16'h0000;   // zero word = add A,A,A
    for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
    dmem[12] = 8'd200;
    dmem[13] = 8'd100;
    imem[250] = 16'h800C;  // load #12 -> A
    imem[251] = 16'h810D;  // load #13 -> B
    imem[252] = 16'h0600;  // add A,B -> C
    imem[253] = 16'hC20E;  // store C -> #14
    imem[254] = 16'h5300;  // sub B,A -> D
    imem[255] = 16'hC30F;  // store D -> #15
    imem[256] = 16'h800F;  // load #15 -> A
    for (int i = 0; i < 256; i++) mMem[i] = dmem[i];
    lastRetired = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 pc", 32'(dbgPc), 32'(START));
    chk("R1 ir", 32'(dbgIr), 32'h0);
    chk("R1 regs", dbgRegs, 32'h0);
    rst = 0;

    for (int cyc = 0; cyc < 80; cyc++) begin
      @(negedge clk);
      chk("R2 R4 pc", 32'(dbgPc), 32'(mPc));
      chk("R3 instrAddr", 32'(instrAddr), 32'(mPc));
      chk("R2 R3 ir", 32'(dbgIr), 32'(mIr));
      chk("R5 R6 R8 regs", dbgRegs, {mRegs[3], mRegs[2], mRegs[1], mRegs[0]});
      chk("R7 R8 dataWe", 32'(dataWe), 32'(mPhase == 3 && mIr[15:14] == 2'b11));
      chk("R6 dataRe", 32'(dataRe), 32'(mPhase == 3 && mIr[15:14] == 2'b10));
      if (dataWe || dataRe) chk("R6 R7 dataAddr", 32'(dataAddr), 32'(mIr[7:0]));
      if (dataWe) chk("R7 dataWdata", 32'(dataWdata), 32'(mRegs[mIr[9:8]]));
      chk("R7 R8 mem14", 32'(dmem[14]), 32'(mMem[14]));
      chk("R7 R8 mem15", 32'(dmem[15]), 32'(mMem[15]));
      if (mRetired != lastRetired) begin
        if (mRetired == 4) begin
          chk("R9 pc", 32'(dbgPc), 32'd508);
          chk("R9 mem14", 32'(dmem[14]), 32'd44);   // (200+100) mod 256
        end
        if (mRetired == 6) chk("R5 R7 mem15", 32'(dmem[15]), 32'd156); // (100-200) mod 256
        if (mRetired == 7) chk("R6 regA", 32'(dbgRegs[7:0]), 32'd156);
        lastRetired = mRetired;
      end
    end
    chk("R9 retired", 32'(mRetired >= 8), 32'd1);
    finishRun();
  end
endmodule